// File: doc/BRIEF.md
# Toggle-on-write interrupt status controller

This block collects interrupt events for a serial-peripheral controller and drives one level-sensitive interrupt line. Three registers sit behind a small word-addressed register port that only takes full 32-bit accesses:

- a 32-bit status register that latches events;
- a 32-bit per-bit enable register;
- a global-enable register that holds a single bit at its top position.

Software acknowledges an event by writing a one to its status bit. The write is an XOR, so the same write can also set a bit that is clear.

The event inputs come from the receive and transmit FIFOs and from the transfer engine:

- Overrun, transmit-empty, transmit-underrun and transmit-half-empty are single-cycle pulses.
- Receive-not-empty and receive-full are levels. They set their status bits on every cycle in which they are high, so a bit stays set until the condition behind it is gone.

The interrupt output is the global enable ANDed with the OR of (status AND enable). It is taken from a register, one clock after the registers it depends on.

Top module: `irq_toggle_ctrl`

## Requirements
- R1: After reset, the status, enable and global-enable registers read as zero and `irq_o` is low.
- R2: A write to byte offset 0x20 replaces the status register with its old value XOR the written data, on all 32 bits.
- R3: A write to byte offset 0x28 stores all 32 bits of the enable register, and a read of 0x28 returns them.
- R4: At byte offset 0x1C only bit 31 is stored, as the global enable. A read of 0x1C returns that bit in position 31 and zeros in bits 30..0.
- R5: Each event sets its own status bit one clock after its pulse: receive-not-empty sets bit 8, receive-full bit 4, receive-overrun bit 5, transmit-empty bit 2, transmit-underrun bit 3 and transmit-half-empty bit 6.
- R6: While `rx_nonempty_i` (bit 8) or `rx_full_i` (bit 4) is high, its status bit is set again on every clock, so an XOR write cannot clear it.
- R7: When an event and a status write reach the same bit in the same cycle, the event wins and the bit ends up set. The other written bits toggle as usual.
- R8: `irq_o` equals the global enable AND the OR of (status AND enable), sampled one clock after those registers change.
- R9: A write to any other offset, or to an address whose bits 1..0 are not zero, changes no register. A read of such an address returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_i | input | 1 | Write strobe for the register port |
| reg_addr_i | input | 8 | Byte address; bits 1..0 must be zero for a hit |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for `reg_addr_i` (combinational) |
| rx_nonempty_i | input | 1 | Level: receive FIFO holds data |
| rx_full_i | input | 1 | Level: receive FIFO is full |
| rx_overrun_i | input | 1 | Pulse: receive data was lost |
| tx_empty_i | input | 1 | Pulse: transmit FIFO drained |
| tx_underrun_i | input | 1 | Pulse: transmit underrun |
| tx_half_empty_i | input | 1 | Pulse: transmit FIFO is half empty |
| irq_o | output | 1 | Registered interrupt line |

## Verification
The assertions assume that an idle event input stays low for the whole cycle. They also assume that `reg_wdata_i` and `reg_addr_i` are steady at a clock edge where `reg_wr_i` is high. The bench meets both by changing every input only on falling edges. It raises a pulse event for exactly one cycle, and it holds the two receive levels for as long as a scenario needs. Where a scenario needs a write and an event to land on the same edge, the bench drives both in the same half-cycle.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;
  localparam int unsigned DATA_W = 32;

  localparam logic [31:0] OFF_GIE    = 32'h1C;
  localparam logic [31:0] OFF_STATUS = 32'h20;
  localparam logic [31:0] OFF_ENABLE = 32'h28;

  localparam int unsigned BIT_RX_NE    = 8;
  localparam int unsigned BIT_RX_FULL  = 4;
  localparam int unsigned BIT_RX_OVR   = 5;
  localparam int unsigned BIT_TX_EMPTY = 2;
  localparam int unsigned BIT_TX_UNDR  = 3;
  localparam int unsigned BIT_TX_HALF  = 6;
  localparam int unsigned BIT_GIE      = DATA_W - 1;

  typedef logic [DATA_W-1:0] word_t;

  // Places each event input on its status bit position.
  function automatic word_t pack_events(input logic rx_ne, input logic rx_full,
                                        input logic rx_ovr, input logic tx_empty,
                                        input logic tx_undr, input logic tx_half);
    word_t v;
    v = '0;
    v[BIT_RX_NE]    = rx_ne;
    v[BIT_RX_FULL]  = rx_full;
    v[BIT_RX_OVR]   = rx_ovr;
    v[BIT_TX_EMPTY] = tx_empty;
    v[BIT_TX_UNDR]  = tx_undr;
    v[BIT_TX_HALF]  = tx_half;
    return v;
  endfunction

  // Interrupt request before the output register.
  function automatic logic irq_pending(input word_t st, input word_t en, input logic gie);
    return gie && (|(st & en));
  endfunction
endpackage

// File: rtl/irq_reg_port.sv
module irq_reg_port
  import irq_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  word_t             status_i,
  input  word_t             enable_i,
  input  logic              gie_i,
  output logic              wr_status_o,
  output logic              wr_enable_o,
  output logic              wr_gie_o,
  output word_t             rdata_o
);
  localparam int unsigned WORD_W = ADDR_W - 2;

  logic              aligned;
  logic [WORD_W-1:0] word_idx;
  logic              hit_status, hit_enable, hit_gie;

  assign aligned    = (addr_i[1:0] == 2'b00);
  assign word_idx   = addr_i[ADDR_W-1:2];
  assign hit_status = aligned && (word_idx == OFF_STATUS[ADDR_W-1:2]);
  assign hit_enable = aligned && (word_idx == OFF_ENABLE[ADDR_W-1:2]);
  assign hit_gie    = aligned && (word_idx == OFF_GIE[ADDR_W-1:2]);

  assign wr_status_o = wr_i && hit_status;
  assign wr_enable_o = wr_i && hit_enable;
  assign wr_gie_o    = wr_i && hit_gie;

  always_comb begin
    rdata_o = '0;
    if (hit_status) rdata_o = status_i;
    if (hit_enable) rdata_o = enable_i;
    if (hit_gie)    rdata_o[BIT_GIE] = gie_i;
  end

  // R9: one address never selects two registers
  always_comb begin
    p_one_target_r9: assert ($onehot0({hit_status, hit_enable, hit_gie}));
  end
endmodule

// File: rtl/irq_status_bank.sv
module irq_status_bank
  import irq_ctrl_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  wr_i,
  input  word_t wdata_i,
  input  word_t ev_i,
  output word_t status_o
);
  word_t st_q;

  for (genvar k = 0; k < DATA_W; k++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        st_q[k] <= 1'b0;
      else if (ev_i[k])  st_q[k] <= 1'b1;
      else if (wr_i)     st_q[k] <= st_q[k] ^ wdata_i[k];
    end
  end

  assign status_o = st_q;

  p_event_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (|ev_i) |=> ((st_q & $past(ev_i)) == $past(ev_i)));

  p_xor_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && ev_i == '0) |=> (st_q == ($past(st_q) ^ $past(wdata_i))));

  p_event_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && (|(ev_i & wdata_i))) |=> ((st_q & $past(ev_i)) == $past(ev_i)));

  p_hold_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_i && ev_i == '0) |=> $stable(st_q));
endmodule

// File: rtl/irq_mask_regs.sv
module irq_mask_regs
  import irq_ctrl_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  wr_enable_i,
  input  logic  wr_gie_i,
  input  word_t wdata_i,
  output word_t enable_o,
  output logic  gie_o
);
  word_t en_q;
  logic  gie_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= '0;
      gie_q <= 1'b0;
    end else begin
      if (wr_enable_i) en_q  <= wdata_i;
      if (wr_gie_i)    gie_q <= wdata_i[BIT_GIE];
    end
  end

  assign enable_o = en_q;
  assign gie_o    = gie_q;

  p_enable_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_enable_i |=> $stable(en_q));

  p_gie_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_gie_i |=> $stable(gie_q));
endmodule

// File: rtl/irq_out_gate.sv
module irq_out_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic pending_i,
  output logic irq_o
);
  logic irq_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= pending_i;
  end

  assign irq_o = irq_q;

  p_irq_latency_r8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq_o == $past(pending_i)));
endmodule

// File: rtl/irq_toggle_ctrl.sv
module irq_toggle_ctrl
  import irq_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  input  logic              rx_nonempty_i,
  input  logic              rx_full_i,
  input  logic              rx_overrun_i,
  input  logic              tx_empty_i,
  input  logic              tx_underrun_i,
  input  logic              tx_half_empty_i,
  output logic              irq_o
);
  word_t status_w, enable_w, ev_w;
  logic  gie_w, wr_status_w, wr_enable_w, wr_gie_w, pending_w;

  assign ev_w = pack_events(rx_nonempty_i, rx_full_i, rx_overrun_i,
                            tx_empty_i, tx_underrun_i, tx_half_empty_i);

  irq_reg_port #(.ADDR_W(ADDR_W)) u_port (
    .wr_i        (reg_wr_i),
    .addr_i      (reg_addr_i),
    .status_i    (status_w),
    .enable_i    (enable_w),
    .gie_i       (gie_w),
    .wr_status_o (wr_status_w),
    .wr_enable_o (wr_enable_w),
    .wr_gie_o    (wr_gie_w),
    .rdata_o     (reg_rdata_o)
  );

  irq_status_bank u_status (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_i     (wr_status_w),
    .wdata_i  (reg_wdata_i),
    .ev_i     (ev_w),
    .status_o (status_w)
  );

  irq_mask_regs u_mask (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_enable_i (wr_enable_w),
    .wr_gie_i    (wr_gie_w),
    .wdata_i     (reg_wdata_i),
    .enable_o    (enable_w),
    .gie_o       (gie_w)
  );

  assign pending_w = irq_pending(status_w, enable_w, gie_w);

  irq_out_gate u_gate (
    .clk       (clk),
    .rst_n     (rst_n),
    .pending_i (pending_w),
    .irq_o     (irq_o)
  );

  // R6: a receive level that is high shows up in status on the next cycle
  p_rx_level_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_nonempty_i || rx_full_i) |=>
      ((!$past(rx_nonempty_i) || status_w[BIT_RX_NE]) &&
       (!$past(rx_full_i)     || status_w[BIT_RX_FULL])));
endmodule

// File: tb/irq_toggle_ctrl_tb_top.sv
`timescale 1ns/1ps
module irq_toggle_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_addr = 8'h0;
  logic [31:0] reg_wdata = 32'h0;
  logic [31:0] reg_rdata;
  logic        rx_ne = 1'b0, rx_full = 1'b0, rx_ovr = 1'b0;
  logic        tx_empty = 1'b0, tx_undr = 1'b0, tx_half = 1'b0;
  logic        irq;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  localparam logic [7:0] A_GIE = 8'h1C, A_ST = 8'h20, A_EN = 8'h28;

  always #5 clk = ~clk;

  irq_toggle_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr_i(reg_wr), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .rx_nonempty_i(rx_ne), .rx_full_i(rx_full), .rx_overrun_i(rx_ovr),
    .tx_empty_i(tx_empty), .tx_underrun_i(tx_undr), .tx_half_empty_i(tx_half),
    .irq_o(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic clear_status();
    logic [31:0] v;
    rd(A_ST, v);
    wr(A_ST, v);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(A_ST, v);  check("R1 status", v, 32'h0);
    rd(A_EN, v);  check("R1 enable", v, 32'h0);
    rd(A_GIE, v); check("R1 gie", v, 32'h0);
    check("R1 irq", {31'h0, irq}, 32'h0);
  endtask

  task automatic t_gie();
    logic [31:0] v;
    wr(A_GIE, 32'hFFFF_FFFF);
    rd(A_GIE, v); check("R4 only bit31", v, 32'h8000_0000);
    wr(A_GIE, 32'h7FFF_FFFF);
    rd(A_GIE, v); check("R4 cleared", v, 32'h0);
  endtask

  task automatic t_enable();
    logic [31:0] v;
    wr(A_EN, 32'hA5A5_0F0F);
    rd(A_EN, v); check("R3 readback", v, 32'hA5A5_0F0F);
    wr(A_EN, 32'h0);
    rd(A_EN, v); check("R3 zero", v, 32'h0);
  endtask

  task automatic pulse_one(input int idx);
    rx_ne = (idx == 0); rx_full = (idx == 1); rx_ovr = (idx == 2);
    tx_empty = (idx == 3); tx_undr = (idx == 4); tx_half = (idx == 5);
    @(negedge clk);
    {rx_ne, rx_full, rx_ovr, tx_empty, tx_undr, tx_half} = '0;
  endtask

  task automatic t_events();
    logic [31:0] v;
    int pos[6] = '{8, 4, 5, 2, 3, 6};
    for (int i = 0; i < 6; i++) begin
      clear_status();
      pulse_one(i);
      rd(A_ST, v);
      check($sformatf("R5 event %0d", i), v, 32'h1 << pos[i]);
    end
    clear_status();
  endtask

  task automatic t_toggle();
    logic [31:0] v;
    wr(A_ST, 32'h8000_1001);
    rd(A_ST, v); check("R2 set by xor", v, 32'h8000_1001);
    wr(A_ST, 32'h0000_1000);
    rd(A_ST, v); check("R2 partial toggle", v, 32'h8000_0001);
    wr(A_ST, 32'h8000_0001);
    rd(A_ST, v); check("R2 cleared", v, 32'h0);
  endtask

  task automatic t_rx_level();
    logic [31:0] v;
    rx_ne = 1'b1; rx_full = 1'b1;
    @(negedge clk);
    wr(A_ST, 32'h0000_0110);
    rd(A_ST, v); check("R6 levels re-set", v, 32'h0000_0110);
    rx_ne = 1'b0; rx_full = 1'b0;
    wr(A_ST, 32'h0000_0110);
    rd(A_ST, v); check("R6 clears after drop", v, 32'h0);
  endtask

  task automatic t_priority();
    logic [31:0] v;
    wr(A_ST, 32'h0000_0020);
    rx_ovr = 1'b1; reg_wr = 1'b1; reg_addr = A_ST; reg_wdata = 32'h0000_0021;
    @(negedge clk);
    rx_ovr = 1'b0; reg_wr = 1'b0;
    rd(A_ST, v); check("R7 event wins", v, 32'h0000_0021);
    clear_status();
  endtask

  task automatic t_irq();
    logic [31:0] v;
    wr(A_EN, 32'h0000_0004);
    wr(A_GIE, 32'h0);
    pulse_one(3);
    @(negedge clk);
    check("R8 gie off", {31'h0, irq}, 32'h0);
    wr(A_GIE, 32'h8000_0000);
    check("R8 one-cycle delay", {31'h0, irq}, 32'h0);
    @(negedge clk);
    check("R8 asserted", {31'h0, irq}, 32'h1);
    wr(A_EN, 32'h0000_0008);
    @(negedge clk);
    check("R8 disabled bit", {31'h0, irq}, 32'h0);
    wr(A_EN, 32'h0000_0004);
    @(negedge clk);
    check("R8 re-enabled", {31'h0, irq}, 32'h1);
    wr(A_ST, 32'h0000_0004);
    check("R8 still high one cycle", {31'h0, irq}, 32'h1);
    @(negedge clk);
    check("R8 deasserted", {31'h0, irq}, 32'h0);
    rd(A_ST, v); check("R8 status clear", v, 32'h0);
  endtask

  task automatic t_unmapped();
    logic [31:0] v;
    wr(A_ST, 32'h0000_0040);
    wr(A_EN, 32'h0000_00FF);
    wr(8'h24, 32'hFFFF_FFFF);
    wr(8'h40, 32'hFFFF_FFFF);
    wr(8'h21, 32'hFFFF_FFFF);
    wr(8'h29, 32'h0);
    rd(8'h24, v); check("R9 read unmapped", v, 32'h0);
    rd(8'h21, v); check("R9 read misaligned", v, 32'h0);
    rd(A_ST, v);  check("R9 status untouched", v, 32'h0000_0040);
    rd(A_EN, v);  check("R9 enable untouched", v, 32'h0000_00FF);
    rd(A_GIE, v); check("R9 gie untouched", v, 32'h8000_0000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_gie();
    t_enable();
    t_events();
    t_toggle();
    t_rx_level();
    t_priority();
    t_irq();
    t_unmapped();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end
endmodule